// File: doc/BRIEF.md
# Non-redundant radix-4 signed-digit recoder

This block turns an N-bit two's complement coefficient into N/2 radix-4 signed digits. Every digit but the most significant one is drawn from a four-value set, so it fits in exactly two bits. The most significant digit carries the full sign range of the input and is given as a sign/one/two triple, in the same style as a Booth digit. A build-time parameter selects one of two digit sets for the lower digits. The negative-leaning form uses {-2,-1,0,+1}. The positive-leaning form uses {-1,0,+1,+2}.

Each lower digit is built from two half adders. One is an ordinary half adder. The other is a signed half adder whose sum bit has negative weight. A single carry ripples through the digits from the least significant end. The block is purely combinational. It is meant to pre-encode constant coefficients before they are stored in a coefficient memory, or to serve as a golden model for such a memory. The same code serves for synthesis into a recoding stage.

Top module: `nr4sd_recoder`

## Requirements
- R1: With PLUS_FORM=0, each lower digit j sits at low_digits_o[2j+1:2j] as {hi,lo}. Its value is lo - 2*hi, which gives {0,0}=0, {0,1}=+1, {1,0}=-2 and {1,1}=-1.
- R2: With PLUS_FORM=1, each lower digit uses the same field layout. Its value is 2*hi - lo, which gives {0,0}=0, {0,1}=-1, {1,0}=+2 and {1,1}=+1.
- R3: For every input, the sum of digit_j*4^j over all N/2 digits equals the signed value of coef_i. This holds for both variants.
- R4: The top digit has the value (msd_two_o ? 2 : msd_one_o ? 1 : 0), negated when msd_neg_o is 1. msd_one_o and msd_two_o are never both 1.
- R5: msd_neg_o is 0 whenever the magnitude of the top digit is zero.
- R6: A zero coefficient gives all lower fields zero and a top triple of zero.
- R7: The lower digits are unique for a given input. Digit j is the value in the variant's set that is congruent to the remaining value modulo 4, with lower digits removed first. The top digit takes what is left, a value in -2..+2.
- R8: The most negative input, -2^(N-1), gives a top digit of -2. The most positive input, 2^(N-1)-1, gives a top digit of +2. This holds in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coef_i | input | N | Two's complement coefficient to recode |
| low_digits_o | output | 2*(N/2-1) | Lower digits, two bits each, with digit 0 in the least significant field |
| msd_neg_o | output | 1 | Top digit is negative |
| msd_one_o | output | 1 | Top digit magnitude is 1 |
| msd_two_o | output | 1 | Top digit magnitude is 2 |

## Verification
The hardest case to reach is a carry that ripples through every lower digit and then reaches the top-digit encoding. This happens, for example, when runs of ones push the top triplet to +2, or when it lands in the all-ones pattern where the sign must be suppressed. With an 8-bit coefficient, a full sweep of all 256 values drives every carry path and every top triplet in both variants. Each result is compared with digits the bench derives by repeated modulo-4 reduction of the input.

// File: rtl/nr4sd_pkg.sv
// Shared types and helpers for the signed-digit recoder.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package nr4sd_pkg;

    // Top digit in sign/magnitude form: at most one of one/two is set.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } msd_code_t;

    // Booth-style encoding of the triplet (hi, lo, cin).
    // The value is -2*hi + lo + cin; a zero result never carries a sign.
    function automatic msd_code_t msd_from_triplet(input logic hi,
                                                   input logic lo,
                                                   input logic cin);
        msd_code_t r;
        r.one = lo ^ cin;
        r.two = (hi & ~lo & ~cin) | (~hi & lo & cin);
        r.neg = hi & ~(lo & cin);
        return r;
    endfunction

endpackage

// File: rtl/nr4sd_lower_cell.sv
// One lower radix-4 digit: two half adders in series, one with a
// negatively weighted sum. PLUS_FORM picks which bit feeds the signed
// adder. Assumes a carry-in of 0 or 1 from the digit below.
module nr4sd_lower_cell #(
    parameter bit PLUS_FORM = 1'b0
) (
    input  logic b_even_i,
    input  logic b_odd_i,
    input  logic c_in_i,
    output logic n_even_o,
    output logic n_odd_o,
    output logic c_out_o
);

    logic c_mid;

    generate
        if (PLUS_FORM) begin : g_plus
            // Even bit: signed half adder, b + c = 2*carry - sum.
            always_comb begin
                n_even_o = b_even_i ^ c_in_i;
                c_mid    = b_even_i | c_in_i;
            end
            // Odd bit: ordinary half adder, b + c = 2*carry + sum.
            always_comb begin
                n_odd_o = b_odd_i ^ c_mid;
                c_out_o = b_odd_i & c_mid;
            end
        end else begin : g_minus
            // Even bit: ordinary half adder.
            always_comb begin
                n_even_o = b_even_i ^ c_in_i;
                c_mid    = b_even_i & c_in_i;
            end
            // Odd bit: signed half adder with negative sum weight.
            always_comb begin
                n_odd_o = b_odd_i ^ c_mid;
                c_out_o = b_odd_i | c_mid;
            end
        end
    endgenerate

endmodule

// File: rtl/nr4sd_msd_enc.sv
// Most significant digit: Booth encoding of the two top coefficient
// bits plus the carry from the lower chain. Assumes the top bit is the
// sign bit of the coefficient.
module nr4sd_msd_enc
    import nr4sd_pkg::*;
(
    input  logic      b_hi_i,
    input  logic      b_lo_i,
    input  logic      c_in_i,
    output msd_code_t code_o
);

    // Encode the triplet into sign/one/two.
    always_comb code_o = msd_from_triplet(b_hi_i, b_lo_i, c_in_i);

endmodule

// File: rtl/nr4sd_recoder.sv
// Top of the recoder: ripples the carry through N/2-1 lower cells and
// Booth-encodes the top digit. Purely combinational.
// Assumes N is even and at least 4.
module nr4sd_recoder
    import nr4sd_pkg::*;
#(
    parameter int N         = 16,
    parameter bit PLUS_FORM = 1'b0
) (
    input  logic [N-1:0]            coef_i,
    output logic [2*(N/2-1)-1:0]    low_digits_o,
    output logic                    msd_neg_o,
    output logic                    msd_one_o,
    output logic                    msd_two_o
);

    localparam int K = N / 2;

    logic [K-1:0] chain_c;
    msd_code_t    msd_code;

    // Carry into digit 0 is zero.
    assign chain_c[0] = 1'b0;

    genvar j;
    generate
        for (j = 0; j < K - 1; j++) begin : g_digit
            nr4sd_lower_cell #(
                .PLUS_FORM (PLUS_FORM)
            ) cell_i (
                .b_even_i (coef_i[2*j]),
                .b_odd_i  (coef_i[2*j+1]),
                .c_in_i   (chain_c[j]),
                .n_even_o (low_digits_o[2*j]),
                .n_odd_o  (low_digits_o[2*j+1]),
                .c_out_o  (chain_c[j+1])
            );
        end
    endgenerate

    nr4sd_msd_enc msd_i (
        .b_hi_i (coef_i[N-1]),
        .b_lo_i (coef_i[N-2]),
        .c_in_i (chain_c[K-1]),
        .code_o (msd_code)
    );

    // Split the top digit code onto its output pins.
    always_comb begin
        msd_neg_o = msd_code.neg;
        msd_one_o = msd_code.one;
        msd_two_o = msd_code.two;
    end

endmodule

// File: rtl/nr4sd_recoder_chk.sv
// Checker for the recoder: relates the digit outputs to the coefficient
// input. Assumes N <= 62 so that the weighted sum fits a longint.
module nr4sd_recoder_chk #(
    parameter int N         = 16,
    parameter bit PLUS_FORM = 1'b0
) (
    input logic [N-1:0]         coef_i,
    input logic [2*(N/2-1)-1:0] low_digits_o,
    input logic                 msd_neg_o,
    input logic                 msd_one_o,
    input logic                 msd_two_o
);

    localparam int K = N / 2;

    longint recon;
    longint top_val;

    // Rebuild the value from the digit outputs.
    always_comb begin
        recon = 0;
        for (int j = 0; j < K - 1; j++) begin
            if (PLUS_FORM)
                recon = recon + (2 * longint'(low_digits_o[2*j+1]) - longint'(low_digits_o[2*j])) * (64'sd1 <<< (2*j));
            else
                recon = recon + (longint'(low_digits_o[2*j]) - 2 * longint'(low_digits_o[2*j+1])) * (64'sd1 <<< (2*j));
        end
        top_val = msd_two_o ? 2 : (msd_one_o ? 1 : 0);
        if (msd_neg_o) top_val = -top_val;
        recon = recon + top_val * (64'sd1 <<< (2*(K-1)));
    end

    // Immediate checks, skipped while inputs are still unknown.
    always_comb begin
        if (!$isunknown(coef_i)) begin
            assert_sum_matches_R3 : assert (recon == longint'($signed(coef_i)));
            assert_top_single_mag_R4 : assert (!(msd_one_o && msd_two_o));
            assert_zero_unsigned_R5 : assert (!msd_neg_o || msd_one_o || msd_two_o);
            if (coef_i == '0) begin
                assert_zero_input_R6 : assert (low_digits_o == '0 && !msd_neg_o && !msd_one_o && !msd_two_o);
            end
            if (coef_i == {1'b1, {(N-1){1'b0}}}) begin
                assert_most_negative_R8 : assert (msd_neg_o && msd_two_o);
            end
            if (coef_i == {1'b0, {(N-1){1'b1}}}) begin
                assert_most_positive_R8 : assert (!msd_neg_o && msd_two_o);
            end
        end
    end

endmodule

bind nr4sd_recoder nr4sd_recoder_chk #(
    .N         (N),
    .PLUS_FORM (PLUS_FORM)
) chk_i (
    .coef_i       (coef_i),
    .low_digits_o (low_digits_o),
    .msd_neg_o    (msd_neg_o),
    .msd_one_o    (msd_one_o),
    .msd_two_o    (msd_two_o)
);

// File: tb/nr4sd_recoder_tb_top.sv
// Exhaustive sweep of an 8-bit configuration in both digit-set variants.
module nr4sd_recoder_tb_top;

    localparam int N  = 8;
    localparam int K  = N / 2;
    localparam int LW = 2 * (K - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]  coef;
    logic [LW-1:0] low_m, low_p;
    logic          neg_m, one_m, two_m, neg_p, one_p, two_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    nr4sd_recoder #(.N(N), .PLUS_FORM(1'b0)) dut_i (
        .coef_i (coef), .low_digits_o (low_m),
        .msd_neg_o (neg_m), .msd_one_o (one_m), .msd_two_o (two_m)
    );

    nr4sd_recoder #(.N(N), .PLUS_FORM(1'b1)) dut_plus_i (
        .coef_i (coef), .low_digits_o (low_p),
        .msd_neg_o (neg_p), .msd_one_o (one_p), .msd_two_o (two_p)
    );

    // Decode a 2-bit field per R1 / R2 tables.
    function automatic int field_val(bit plus, logic [1:0] f);
        if (plus) return 2 * int'(f[1]) - int'(f[0]);
        return int'(f[0]) - 2 * int'(f[1]);
    endfunction

    // Expected field for a digit value per R1 / R2 tables.
    function automatic logic [1:0] field_of(bit plus, int d);
        if (!plus) begin
            case (d)
                1: return 2'b01;  -2: return 2'b10;  -1: return 2'b11;
                default: return 2'b00;
            endcase
        end
        case (d)
            -1: return 2'b01;  2: return 2'b10;  1: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check_one(input int v, input bit plus, input logic [LW-1:0] low,
                             input logic neg, input logic one, input logic two);
        int r;
        int m;
        int d;
        int recon;
        int topv;
        logic [2:0] exp_top;
        r = v;
        recon = 0;
        for (int j = 0; j < K - 1; j++) begin
            m = ((r % 4) + 4) % 4;
            if (plus) d = (m == 3) ? -1 : m;
            else      d = (m >= 2) ? m - 4 : m;
            r = (r - d) / 4;
            checks++;
            if (low[2*j +: 2] !== field_of(plus, d)) begin
                errors++;
                $display("FAIL %s v=%0d digit %0d: got %b expected %b",
                         plus ? "R2/R7" : "R1/R7", v, j, low[2*j +: 2], field_of(plus, d));
            end
            recon = recon + field_val(plus, low[2*j +: 2]) * (4 ** j);
        end
        // R4 / R5: top digit triple from the remainder.
        exp_top = {r < 0, (r == 1 || r == -1), (r == 2 || r == -2)};
        checks++;
        if ({neg, one, two} !== exp_top) begin
            errors++;
            $display("FAIL R4/R5 v=%0d plus=%0d top: got %b expected %b", v, plus, {neg, one, two}, exp_top);
        end
        topv = two ? 2 : (one ? 1 : 0);
        if (neg) topv = -topv;
        recon = recon + topv * (4 ** (K - 1));
        checks++;
        if (recon != v) begin
            errors++;
            $display("FAIL R3 v=%0d plus=%0d sum: got %0d expected %0d", v, plus, recon, v);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        coef = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: zero coefficient gives all-zero outputs.
        checks++;
        if (low_m !== '0 || {neg_m, one_m, two_m} !== 3'b000 ||
            low_p !== '0 || {neg_p, one_p, two_p} !== 3'b000) begin
            errors++;
            $display("FAIL R6 zero input: got %b/%b %b/%b expected all zero",
                     low_m, {neg_m, one_m, two_m}, low_p, {neg_p, one_p, two_p});
        end
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R7: full sweep of all coefficients.
        for (int v = -(2 ** (N-1)); v < 2 ** (N-1); v++) begin
            @(posedge clk);
            coef = v[N-1:0];
            @(negedge clk);
            check_one(v, 1'b0, low_m, neg_m, one_m, two_m);
            check_one(v, 1'b1, low_p, neg_p, one_p, two_p);
        end

        // R8: extremes give top digits -2 and +2 in both variants.
        @(posedge clk);
        coef = {1'b1, {(N-1){1'b0}}};
        @(negedge clk);
        checks++;
        if ({neg_m, one_m, two_m} !== 3'b101 || {neg_p, one_p, two_p} !== 3'b101) begin
            errors++;
            $display("FAIL R8 most negative: got %b/%b expected 101/101",
                     {neg_m, one_m, two_m}, {neg_p, one_p, two_p});
        end
        @(posedge clk);
        coef = {1'b0, {(N-1){1'b1}}};
        @(negedge clk);
        checks++;
        if ({neg_m, one_m, two_m} !== 3'b001 || {neg_p, one_p, two_p} !== 3'b001) begin
            errors++;
            $display("FAIL R8 most positive: got %b/%b expected 001/001",
                     {neg_m, one_m, two_m}, {neg_p, one_p, two_p});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule